// File: doc/BRIEF.md
# CAN Fault Confinement State Machine

This block keeps the error bookkeeping of one CAN node. It holds a transmit error counter and a receive error counter, and it works out from them whether the node is error-active, error-passive or bus-off. Other logic detects errors on the wire and serialises frames. That logic sends this block one-cycle event pulses: transmit error, receive error, successful transmit and successful receive. This block answers with the counter values, the current state, the kind of error flag the node must drive, and the number of suspend-transmission bits to add after intermission.

When the transmit counter overflows, the node goes bus-off and ignores all further events. Recovery waits until the host has left reset mode. The block then watches the sampled bus bit on each bit strobe and counts runs of 11 consecutive recessive bits. After 128 such runs the node returns to error-active with both counters cleared. Every state change sets a sticky interrupt, and a host read pulse clears it.

Top module: `fault_confine`

## Requirements
- R1: After reset both counters read 0, `state` reads 0 (error-active), `irq` is 0, `flagRecessive` is 0 and `suspendBits` is 0.
- R2: Outside bus-off, a `txErr` pulse adds 8 to `txCnt`. A `txOk` pulse subtracts 1, but never below 0. When both arrive in the same cycle, only the error is applied.
- R3: Outside bus-off, an `rxErr` pulse adds 1 to `rxCnt`, saturating at 255. An `rxOk` pulse subtracts 1, but never below 0. When both arrive in the same cycle, only the error is applied.
- R4: `state` encodes 0 as error-active, 1 as error-passive and 2 as bus-off. Outside bus-off the state is 1 when either counter is 128 or more, and 0 otherwise. The state follows the counters one clock after the counter update.
- R5: A `txErr` that would take `txCnt` above 255 puts the node in bus-off. `txCnt` then reads 255. While bus-off, all four event inputs leave both counters unchanged.
- R6: In error-passive, `flagRecessive` is 1, meaning the flag is six recessive bits, and `suspendBits` is 8. In every other state `flagRecessive` is 0, meaning the flag is six dominant bits, and `suspendBits` is 0.
- R7: While `resetMode` is 1, bus-off recovery makes no progress. With `resetMode` at 0, every `bitStrobe` with `busBit`=1 (recessive) extends the current run. A run is complete at 11 such bits. A dominant bit (`busBit`=0) discards the partial run.
- R8: After 128 completed runs the node leaves bus-off for error-active, with both counters at 0.
- R9: Every change of `state` sets `irq`, and `irq` stays set until an `irqRead` pulse clears it. If a state change and `irqRead` fall in the same cycle, `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txErr | input | 1 | Transmit error event pulse |
| rxErr | input | 1 | Receive error event pulse |
| txOk | input | 1 | Successful transmit pulse |
| rxOk | input | 1 | Successful receive pulse |
| busBit | input | 1 | Sampled bus level, 1 = recessive |
| bitStrobe | input | 1 | One pulse per sampled bit |
| resetMode | input | 1 | Host reset mode; recovery is held while 1 |
| irqRead | input | 1 | Host read pulse that clears the interrupt |
| txCnt | output | 8 | Transmit error counter |
| rxCnt | output | 8 | Receive error counter |
| state | output | 2 | 0 active, 1 passive, 2 bus-off |
| flagRecessive | output | 1 | Error flag made of recessive bits |
| suspendBits | output | 4 | Suspend bits to add after intermission |
| irq | output | 1 | Sticky state-change interrupt |

## Verification
Two functions can land in the same cycle. The first is a state change that sets the interrupt. The second is a host read that clears it. The bench provokes this by raising `txErr` together with `txOk` so that the transmit counter crosses 128. It then pulses `irqRead` in the cycle in which the state register moves to error-passive. The check expects `irq` to stay at 1, and `txCnt` to show only the +8 of the error. A later plain read is expected to clear `irq`.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic evtEn;    // counters follow event pulses
    logic clrAll;   // clear counters after recovery
    logic recovEn;  // recessive-run counting allowed
  } fcStrobe_t;

endpackage

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int TX_STEP    = 8,
  parameter int RUN_LEN    = 11,
  parameter int RECOV_RUNS = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErr,
  input  logic             rxErr,
  input  logic             txOk,
  input  logic             rxOk,
  input  logic             busBit,
  input  logic             bitStrobe,
  input  fcStrobe_t        strobe,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] rxCnt,
  output logic             txOverflow,
  output logic             recovDone
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int REC_W = $clog2(RECOV_RUNS + 1);

  logic [CNT_W-1:0] txCntQ, txNext, rxCntQ, rxNext;
  logic             ovfQ, ovfNext;
  logic [CNT_W:0]   txSum;
  logic [RUN_W-1:0] runLenQ, runLenNext;
  logic [REC_W-1:0] runsQ, runsNext;

  assign txSum = {1'b0, txCntQ} + (CNT_W+1)'(TX_STEP);

  // transmit counter with overflow into bus-off
  always_comb begin
    txNext  = txCntQ;
    ovfNext = ovfQ;
    if (strobe.clrAll) begin
      txNext  = '0;
      ovfNext = 1'b0;
    end else if (strobe.evtEn) begin
      if (txErr) begin
        if (txSum[CNT_W]) begin
          txNext  = CNT_MAX;
          ovfNext = 1'b1;
        end else begin
          txNext = txSum[CNT_W-1:0];
        end
      end else if (txOk && txCntQ != '0) begin
        txNext = txCntQ - 1'b1;
      end
    end
  end

  // receive counter, saturating
  always_comb begin
    rxNext = rxCntQ;
    if (strobe.clrAll) begin
      rxNext = '0;
    end else if (strobe.evtEn) begin
      if (rxErr) begin
        if (rxCntQ != CNT_MAX) rxNext = rxCntQ + 1'b1;
      end else if (rxOk && rxCntQ != '0) begin
        rxNext = rxCntQ - 1'b1;
      end
    end
  end

  // recessive run counting for bus-off recovery
  always_comb begin
    runLenNext = runLenQ;
    runsNext   = runsQ;
    if (!strobe.recovEn || strobe.clrAll) begin
      runLenNext = '0;
      runsNext   = '0;
    end else if (bitStrobe) begin
      if (!busBit) begin
        runLenNext = '0;
      end else if (runLenQ == RUN_W'(RUN_LEN - 1)) begin
        runLenNext = '0;
        if (runsQ != REC_W'(RECOV_RUNS)) runsNext = runsQ + 1'b1;
      end else begin
        runLenNext = runLenQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCntQ  <= '0;
      rxCntQ  <= '0;
      ovfQ    <= 1'b0;
      runLenQ <= '0;
      runsQ   <= '0;
    end else begin
      txCntQ  <= txNext;
      rxCntQ  <= rxNext;
      ovfQ    <= ovfNext;
      runLenQ <= runLenNext;
      runsQ   <= runsNext;
    end
  end

  assign txCnt      = txCntQ;
  assign rxCnt      = rxCntQ;
  assign txOverflow = ovfQ;
  assign recovDone  = (runsQ == REC_W'(RECOV_RUNS));

endmodule

// File: rtl/fc_control.sv
module fc_control
  import fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int SUSPEND_LEN = 8,
  parameter int SUSP_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  txCnt,
  input  logic [CNT_W-1:0]  rxCnt,
  input  logic              txOverflow,
  input  logic              recovDone,
  input  logic              resetMode,
  input  logic              irqRead,
  output fcState_e          stateQ,
  output fcStrobe_t         strobe,
  output logic              irq,
  output logic              flagRecessive,
  output logic [SUSP_W-1:0] suspendBits
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(PASSIVE_LIM);

  fcState_e stateNext;
  logic     overLimit;

  assign overLimit = (txCnt >= LIM) || (rxCnt >= LIM);

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      FC_BUSOFF: if (recovDone) stateNext = FC_ACTIVE;
      default: begin
        if (txOverflow)     stateNext = FC_BUSOFF;
        else if (overLimit) stateNext = FC_PASSIVE;
        else                stateNext = FC_ACTIVE;
      end
    endcase
  end

  always_comb begin
    strobe.evtEn   = (stateQ != FC_BUSOFF) && !txOverflow;
    strobe.clrAll  = (stateQ == FC_BUSOFF) && recovDone;
    strobe.recovEn = (stateQ == FC_BUSOFF) && !resetMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= FC_ACTIVE;
      irq    <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stateNext != stateQ) irq <= 1'b1;
      else if (irqRead)        irq <= 1'b0;
    end
  end

  assign flagRecessive = (stateQ == FC_PASSIVE);
  assign suspendBits   = (stateQ == FC_PASSIVE) ? SUSP_W'(SUSPEND_LEN) : '0;

endmodule

// File: rtl/fault_confine.sv
module fault_confine
  import fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TX_STEP     = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int RUN_LEN     = 11,
  parameter int RECOV_RUNS  = 128,
  parameter int SUSPEND_LEN = 8,
  parameter int SUSP_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txErr,
  input  logic              rxErr,
  input  logic              txOk,
  input  logic              rxOk,
  input  logic              busBit,
  input  logic              bitStrobe,
  input  logic              resetMode,
  input  logic              irqRead,
  output logic [CNT_W-1:0]  txCnt,
  output logic [CNT_W-1:0]  rxCnt,
  output logic [1:0]        state,
  output logic              flagRecessive,
  output logic [SUSP_W-1:0] suspendBits,
  output logic              irq
);

  fcStrobe_t strobe;
  fcState_e  stateQ;
  logic      txOverflow;
  logic      recovDone;

  fc_datapath #(
    .CNT_W(CNT_W), .TX_STEP(TX_STEP), .RUN_LEN(RUN_LEN), .RECOV_RUNS(RECOV_RUNS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .txErr(txErr), .rxErr(rxErr), .txOk(txOk),
    .rxOk(rxOk), .busBit(busBit), .bitStrobe(bitStrobe), .strobe(strobe),
    .txCnt(txCnt), .rxCnt(rxCnt), .txOverflow(txOverflow), .recovDone(recovDone)
  );

  fc_control #(
    .CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM), .SUSPEND_LEN(SUSPEND_LEN), .SUSP_W(SUSP_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .txCnt(txCnt), .rxCnt(rxCnt), .txOverflow(txOverflow),
    .recovDone(recovDone), .resetMode(resetMode), .irqRead(irqRead),
    .stateQ(stateQ), .strobe(strobe), .irq(irq), .flagRecessive(flagRecessive),
    .suspendBits(suspendBits)
  );

  assign state = stateQ;

endmodule

// File: rtl/fc_checker.sv
module fc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       txErr,
  input logic       txOk,
  input logic [7:0] txCnt,
  input logic [7:0] rxCnt,
  input logic [1:0] state,
  input logic       irq,
  input logic       txOverflow,
  input logic       recovDone
);

  // R2: an error step adds exactly 8 when no overflow can happen
  a_r2_tx_step: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && state != 2'd2 && !txOverflow && txCnt <= 8'd247) |=> (txCnt == $past(txCnt) + 8'd8));

  // R2: success at zero keeps the counter at zero
  a_r2_tx_floor: assert property (@(posedge clk) disable iff (!rstN)
    (txOk && !txErr && txCnt == 8'd0) |=> (txCnt == 8'd0));

  // R4: a receive counter at the limit drives the passive state next cycle
  a_r4_rx_passive: assert property (@(posedge clk) disable iff (!rstN)
    (state != 2'd2 && !txOverflow && rxCnt >= 8'd128) |=> (state == 2'd1));

  // R5: counters frozen in bus-off until recovery completes
  a_r5_busoff_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == 2'd2 && !recovDone) |=> (txCnt == $past(txCnt) && rxCnt == $past(rxCnt)));

  // R8: leaving bus-off always comes with cleared counters
  a_r8_recover_clear: assert property (@(posedge clk) disable iff (!rstN)
    (state == 2'd2) |=> (state == 2'd2 || (txCnt == 8'd0 && rxCnt == 8'd0)));

  // R9: every state change is flagged
  a_r9_irq_on_change: assert property (@(posedge clk) disable iff (!rstN)
    (state != $past(state)) |-> irq);

endmodule

bind fault_confine fc_checker u_chk (
  .clk(clk), .rstN(rstN), .txErr(txErr), .txOk(txOk), .txCnt(txCnt),
  .rxCnt(rxCnt), .state(state), .irq(irq), .txOverflow(txOverflow),
  .recovDone(recovDone)
);

// File: tb/fault_confine_tb.sv
module fault_confine_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txErr = 0, rxErr = 0, txOk = 0, rxOk = 0;
  logic busBit = 1, bitStrobe = 0, resetMode = 1, irqRead = 0;
  logic [7:0] txCnt, rxCnt;
  logic [1:0] state;
  logic       flagRecessive, irq;
  logic [3:0] suspendBits;

  always #5 clk = ~clk;

  fault_confine u_dut (
    .clk(clk), .rstN(rstN), .txErr(txErr), .rxErr(rxErr), .txOk(txOk), .rxOk(rxOk),
    .busBit(busBit), .bitStrobe(bitStrobe), .resetMode(resetMode), .irqRead(irqRead),
    .txCnt(txCnt), .rxCnt(rxCnt), .state(state), .flagRecessive(flagRecessive),
    .suspendBits(suspendBits), .irq(irq)
  );

  typedef struct {
    int    tx;
    int    rx;
    int    st;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  event chkEv;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // reference model state
  int   txM = 0, rxM = 0, stM = 0;
  logic irqM = 0;

  // monitor: compares each expected item against the ports
  initial forever begin
    exp_t e;
    int   expFlag, expSusp;
    @(chkEv);
    e = q.pop_front();
    expFlag = (e.st == 1) ? 1 : 0;
    expSusp = (e.st == 1) ? 8 : 0;
    checks++;
    if (int'(txCnt) != e.tx || int'(rxCnt) != e.rx || int'(state) != e.st ||
        irq != e.irq || int'(flagRecessive) != expFlag || int'(suspendBits) != expSusp) begin
      errors++;
      $display("FAIL %s: got tx=%0d rx=%0d st=%0d irq=%0b flag=%0d susp=%0d, expected tx=%0d rx=%0d st=%0d irq=%0b flag=%0d susp=%0d",
               e.tag, txCnt, rxCnt, state, irq, flagRecessive, suspendBits,
               e.tx, e.rx, e.st, e.irq, expFlag, expSusp);
    end
  end

  task automatic pushExp(input string tag);
    exp_t e;
    e.tx = txM; e.rx = rxM; e.st = stM; e.irq = irqM; e.tag = tag;
    q.push_back(e);
    -> chkEv;
    #1;
  endtask

  // R2..R5 model of one event cycle
  task automatic model(input bit te, input bit re, input bit to, input bit ro);
    int nSt;
    bit bo = 0;
    if (stM == 2) return;
    if (te) begin
      if (txM + 8 > 255) begin txM = 255; bo = 1; end
      else txM = txM + 8;
    end else if (to && txM != 0) txM = txM - 1;
    if (re) begin
      if (rxM != 255) rxM = rxM + 1;
    end else if (ro && rxM != 0) rxM = rxM - 1;
    nSt = bo ? 2 : ((txM >= 128 || rxM >= 128) ? 1 : 0);
    if (nSt != stM) irqM = 1;
    stM = nSt;
  endtask

  task automatic evt(input bit te, input bit re, input bit to, input bit ro,
                     input bit doChk, input string tag);
    @(negedge clk);
    txErr = te; rxErr = re; txOk = to; rxOk = ro;
    @(negedge clk);
    txErr = 0; rxErr = 0; txOk = 0; rxOk = 0;
    @(negedge clk);
    model(te, re, to, ro);
    if (doChk) pushExp(tag);
  endtask

  task automatic readIrq(input string tag);
    @(negedge clk); irqRead = 1;
    @(negedge clk); irqRead = 0;
    irqM = 0;
    pushExp(tag);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); busBit = b; bitStrobe = 1;
    @(negedge clk); bitStrobe = 0; busBit = 1;
  endtask

  // driver
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    pushExp("R1 reset state");

    // R3 receive counter
    evt(0, 1, 0, 0, 0, "");
    evt(0, 1, 0, 0, 0, "");
    evt(0, 1, 0, 0, 1, "R3 rx error increments");
    evt(0, 0, 0, 1, 1, "R3 rx ok decrements");
    evt(0, 1, 0, 1, 1, "R3 rx error wins over rx ok");

    // R2 transmit counter floor
    evt(0, 0, 1, 0, 1, "R2 tx ok at zero stays zero");
    for (int i = 0; i < 15; i++) evt(1, 0, 0, 0, 0, "");
    pushExp("R2 fifteen tx errors give 120");

    // R9 + R2: transition edge coincides with host read
    @(negedge clk); txErr = 1; txOk = 1;
    @(negedge clk); txErr = 0; txOk = 0; irqRead = 1;
    @(negedge clk); irqRead = 0;
    model(1, 0, 1, 0);
    pushExp("R9 set wins over read, R2 error wins, R4 passive at 128, R6 passive flag");
    readIrq("R9 read clears irq");

    evt(0, 0, 1, 0, 1, "R4 back to active at 127, R6 dominant flag");
    readIrq("R9 read clears irq again");

    // R4 passive through the receive counter
    for (int i = 0; i < 125; i++) evt(0, 1, 0, 0, 0, "");
    pushExp("R4 rx reaches 128, passive");
    evt(0, 0, 0, 1, 1, "R4 rx 127, active");
    readIrq("R9 clear");

    // R5 drive into bus-off
    for (int i = 0; i < 17; i++) evt(1, 0, 0, 0, 0, "");
    pushExp("R5 tx overflow gives bus-off at 255");
    evt(1, 1, 1, 1, 1, "R5 events ignored in bus-off");
    evt(0, 0, 1, 1, 1, "R5 ok events ignored in bus-off");
    readIrq("R9 clear in bus-off");

    // R7 no progress while in reset mode
    for (int i = 0; i < 1420; i++) sendBit(1);
    @(negedge clk);
    pushExp("R7 no recovery while reset mode set");

    // R7 partial run discarded by a dominant bit
    @(negedge clk); resetMode = 0;
    for (int i = 0; i < 10; i++) sendBit(1);
    sendBit(0);
    for (int i = 0; i < 127 * 11; i++) sendBit(1);
    @(negedge clk);
    pushExp("R7 only 127 full runs so far");
    for (int i = 0; i < 10; i++) sendBit(1);
    @(negedge clk);
    pushExp("R7 run incomplete at 10 bits");
    sendBit(1);
    @(negedge clk);
    txM = 0; rxM = 0; stM = 0; irqM = 1;
    pushExp("R8 recovered, counters cleared");
    readIrq("R9 clear after recovery");

    // R3 saturation
    for (int i = 0; i < 260; i++) evt(0, 1, 0, 0, 0, "");
    pushExp("R3 rx saturates at 255");

    wait (q.size() == 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule